// File: doc/BRIEF.md
# Idle-Triggered Low-Power Timer for a Disk Controller

This block decides when a disk-controller core may enter its low-power state. It holds a two-bit power mode, written by the host, that picks one of four behaviours: power-down off, automatic power-down after a stretch of idleness, forced power-down at once, and a reserved code that acts like "off". In automatic mode the idle interval depends on the selected data rate. The fast rate waits 512 ms and the slow rate waits 1000 ms. Time is measured in pulses of a 1 ms tick input, so the timeouts do not depend on the system clock frequency.

The low-power flag is the only product of the block. Clock gating and oscillator control live elsewhere and act on this flag. A one-cycle wake pulse marks every cycle in which the flag drops. A soft-reset pulse returns the mode to "off" and clears the flag.

Top module: `lp_idle_timer`

## Requirements
- R1: After `rst_n` is released, `low_pwr_o` and `wake_o` are 0 and the mode is "off" (code 2'b00).
- R2: With mode 2'b00, `low_pwr_o` stays 0 for any number of idle ticks.
- R3: With the reserved mode 2'b11, `low_pwr_o` stays 0 for any number of idle ticks.
- R4: Writing mode 2'b10 (manual) raises `low_pwr_o` in the cycle after the write, whatever `idle_i` is, and keeps it high while the mode stays 2'b10.
- R5: In mode 2'b01 with `rate_sel_i`=1 (fast rate), `low_pwr_o` rises at the clock edge that samples the FAST_MS-th (default 512) tick of unbroken idleness, and not earlier.
- R6: In mode 2'b01 with `rate_sel_i`=0 (slow rate), `low_pwr_o` rises at the edge that samples the SLOW_MS-th (default 1000) tick of unbroken idleness, and not earlier.
- R7: In mode 2'b01, a cycle with `idle_i`=0 clears the idle count and clears `low_pwr_o` at the next edge. The full interval must then pass again.
- R8: A change of `rate_sel_i` while in mode 2'b01 restarts the idle count. The new rate's threshold then applies in full.
- R9: A `soft_rst_i` pulse sets the mode to 2'b00 and clears `low_pwr_o` at the next edge. It wins over a mode write in the same cycle.
- R10: `wake_o` is 1 for exactly the one cycle after `low_pwr_o` falls from 1 to 0, and is 0 at all other times.
- R11: Only cycles with `tick_i`=1 advance the count. Once low power is reached, it holds while idleness continues, and the count never exceeds the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we_i | input | 1 | Write strobe for the power mode |
| mode_wdata_i | input | 2 | New mode: 00 off, 01 auto, 10 manual, 11 reserved |
| soft_rst_i | input | 1 | Soft-reset pulse |
| rate_sel_i | input | 1 | Data-rate select: 1 fast (512 ms), 0 slow (1000 ms) |
| idle_i | input | 1 | High while the controller core is idle |
| tick_i | input | 1 | One-cycle pulse every 1 ms |
| low_pwr_o | output | 1 | Low-power request flag |
| wake_o | output | 1 | One-cycle pulse when low power ends |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse and that all inputs change only between clock edges. They also assume that a mode write and a soft reset are the only ways the mode changes. The bench drives every input on the falling edge and makes each tick a one-cycle pulse followed by a quiet cycle. It holds `rate_sel_i` and `idle_i` steady across tick bursts unless a scenario deliberately breaks idleness or switches the rate between ticks.

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
  parameter int FAST_MS = 512,
  parameter int SLOW_MS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we_i,
  input  logic [1:0] mode_wdata_i,
  input  logic       soft_rst_i,
  input  logic       rate_sel_i,
  input  logic       idle_i,
  input  logic       tick_i,
  output logic       low_pwr_o,
  output logic       wake_o
);

  localparam int MAXL = (FAST_MS > SLOW_MS) ? FAST_MS : SLOW_MS;
  localparam int CW   = $clog2(MAXL + 1);

  localparam logic [1:0] M_OFF    = 2'b00;
  localparam logic [1:0] M_AUTO   = 2'b01;
  localparam logic [1:0] M_MANUAL = 2'b10;

  logic [1:0]    mode_q;
  logic          rate_q;
  logic [CW-1:0] cnt_q;
  logic          auto_lp_q;
  logic          lp_d_q;

  logic [CW-1:0] limit;
  logic          restart;
  logic          last_tick;

  assign limit     = rate_sel_i ? CW'(FAST_MS) : CW'(SLOW_MS);
  assign restart   = soft_rst_i | mode_we_i | (mode_q != M_AUTO) | !idle_i
                   | (rate_sel_i != rate_q);
  assign last_tick = tick_i && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= M_OFF;
    else if (soft_rst_i) mode_q <= M_OFF;
    else if (mode_we_i)  mode_q <= mode_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= 1'b0;
    else        rate_q <= rate_sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (restart)                  cnt_q <= '0;
    else if (tick_i && cnt_q != limit) cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         auto_lp_q <= 1'b0;
    else if (restart)   auto_lp_q <= 1'b0;
    else if (last_tick) auto_lp_q <= 1'b1;
  end

  assign low_pwr_o = (mode_q == M_MANUAL) | auto_lp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_d_q <= 1'b0;
    else        lp_d_q <= low_pwr_o;
  end

  assign wake_o = lp_d_q & ~low_pwr_o;

endmodule

// File: rtl/lp_idle_timer_chk.sv
module lp_idle_timer_chk #(
  parameter int FAST_MS = 512,
  parameter int SLOW_MS = 1000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode_we_i,
  input logic                soft_rst_i,
  input logic                idle_i,
  input logic                tick_i,
  input logic                low_pwr_o,
  input logic                wake_o,
  input logic [1:0]          mode_q,
  input logic [$clog2(((FAST_MS > SLOW_MS) ? FAST_MS : SLOW_MS) + 1)-1:0] cnt_q
);
  localparam int MAXL = (FAST_MS > SLOW_MS) ? FAST_MS : SLOW_MS;

  AST_OFF_NO_LP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> !low_pwr_o);                                   // R2
  AST_RSVD_NO_LP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11) |-> !low_pwr_o);                                   // R3
  AST_MANUAL_LP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10) |-> low_pwr_o);                                    // R4
  AST_AUTO_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && !tick_i && !low_pwr_o && !mode_we_i) |=> !low_pwr_o); // R5
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && !idle_i && !mode_we_i) |=> !low_pwr_o);          // R7
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!low_pwr_o && mode_q == 2'b00));                     // R9
  AST_WAKE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!low_pwr_o && $past(low_pwr_o)));                        // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAXL);                                                      // R11
endmodule

bind lp_idle_timer lp_idle_timer_chk #(.FAST_MS(FAST_MS), .SLOW_MS(SLOW_MS)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_we_i(mode_we_i), .soft_rst_i(soft_rst_i),
  .idle_i(idle_i), .tick_i(tick_i), .low_pwr_o(low_pwr_o), .wake_o(wake_o),
  .mode_q(mode_q), .cnt_q(cnt_q)
);

// File: tb/test_lp_idle_timer.sv
`timescale 1ns/1ps
module test_lp_idle_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [1:0] mode_wdata_i = 2'b00;
  logic       soft_rst_i = 1'b0;
  logic       rate_sel_i = 1'b0;
  logic       idle_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       low_pwr_o;
  logic       wake_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lp_idle_timer i_lp_idle_timer (
    .clk(clk), .rst_n(rst_n), .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
    .soft_rst_i(soft_rst_i), .rate_sel_i(rate_sel_i), .idle_i(idle_i),
    .tick_i(tick_i), .low_pwr_o(low_pwr_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_we_i = 1'b1; mode_wdata_i = m;
    @(negedge clk);
    mode_we_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1 low_pwr after reset", low_pwr_o, 1'b0);
    check("R1 wake after reset", wake_o, 1'b0);
    idle_i = 1'b1; ticks(1100);
    check("R1 mode off after reset", low_pwr_o, 1'b0);
    idle_i = 1'b0; cyc(1);
  endtask

  task automatic t_off_and_reserved;
    write_mode(2'b00); idle_i = 1'b1; ticks(1100);
    check("R2 off mode stays awake", low_pwr_o, 1'b0);
    write_mode(2'b11); ticks(1100);
    check("R3 reserved mode stays awake", low_pwr_o, 1'b0);
    idle_i = 1'b0; write_mode(2'b00);
  endtask

  task automatic t_manual;
    idle_i = 1'b0;
    write_mode(2'b10);
    check("R4 manual immediate", low_pwr_o, 1'b1);
    cyc(20);
    check("R4 manual holds while busy", low_pwr_o, 1'b1);
    write_mode(2'b00);
    check("R10 manual exit clears", low_pwr_o, 1'b0);
    check("R10 wake pulse", wake_o, 1'b1);
    cyc(1);
    check("R10 wake one cycle", wake_o, 1'b0);
  endtask

  task automatic t_auto_fast;
    rate_sel_i = 1'b1; idle_i = 1'b0; cyc(1);
    write_mode(2'b01);
    idle_i = 1'b1; cyc(50);
    ticks(511);
    check("R11 idle cycles without ticks do not count", low_pwr_o, 1'b0);
    check("R5 not before 512th tick", low_pwr_o, 1'b0);
    ticks(1);
    check("R5 low power at 512th tick", low_pwr_o, 1'b1);
    ticks(30);
    check("R11 holds while idle", low_pwr_o, 1'b1);
    check("R10 no wake while low", wake_o, 1'b0);
    idle_i = 1'b0; cyc(1);
    check("R7 activity clears low power", low_pwr_o, 1'b0);
    check("R10 wake on activity", wake_o, 1'b1);
    cyc(1);
    check("R10 wake single cycle", wake_o, 1'b0);
  endtask

  task automatic t_auto_slow;
    rate_sel_i = 1'b0; idle_i = 1'b0; cyc(2);
    idle_i = 1'b1;
    ticks(999);
    check("R6 not before 1000th tick", low_pwr_o, 1'b0);
    ticks(1);
    check("R6 low power at 1000th tick", low_pwr_o, 1'b1);
    idle_i = 1'b0; cyc(2);
  endtask

  task automatic t_busy_glitch;
    rate_sel_i = 1'b1; cyc(1);
    idle_i = 1'b1; ticks(300);
    idle_i = 1'b0; cyc(1);
    idle_i = 1'b1;
    ticks(511);
    check("R7 count restarted after activity", low_pwr_o, 1'b0);
    ticks(1);
    check("R7 full interval after activity", low_pwr_o, 1'b1);
    idle_i = 1'b0; cyc(2);
  endtask

  task automatic t_rate_change;
    rate_sel_i = 1'b0; cyc(1);
    idle_i = 1'b1; ticks(600);
    check("R8 slow rate not yet reached", low_pwr_o, 1'b0);
    rate_sel_i = 1'b1; cyc(1);
    ticks(511);
    check("R8 count restarted on rate change", low_pwr_o, 1'b0);
    ticks(1);
    check("R8 new threshold applies", low_pwr_o, 1'b1);
  endtask

  task automatic t_soft_reset;
    check("R9 precondition low power", low_pwr_o, 1'b1);
    soft_rst_i = 1'b1; mode_we_i = 1'b1; mode_wdata_i = 2'b10;
    @(negedge clk);
    soft_rst_i = 1'b0; mode_we_i = 1'b0;
    check("R9 soft reset clears low power", low_pwr_o, 1'b0);
    ticks(1100);
    check("R9 mode forced off", low_pwr_o, 1'b0);
    idle_i = 1'b0; cyc(1);
  endtask

  initial begin
    fork
      begin
        cyc(3); rst_n = 1'b1; cyc(1);
        t_reset;
        t_off_and_reserved;
        t_manual;
        t_auto_fast;
        t_auto_slow;
        t_busy_glitch;
        t_rate_change;
        t_soft_reset;
      end
      begin
        cyc(150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule